// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a configurable arithmetic slice for datapaths that need a multiply with an optional pre-adder and a post-adder. Operands B and D may be combined first by addition or subtraction. The result, or B alone, is multiplied as a signed value by operand A. The product is sign-extended and added to a Z operand. Z can be zero, an external C word, or the slice's own registered output, and the last choice gives an accumulator. A multiplexer in front of C, outside the slice, can reload the accumulator with a new starting value.

The slice has seven pipeline registers: two on A, one on B before the pre-adder, one after it, one on D, one on the product and one on the output. A parameter keeps or removes each register. The two A stages share one clock enable and one reset, and so do the two B stages. D, the product and the output each have their own enable and reset. Each reset is synchronous, active high and clears its stage to zero. Every register starts at zero and captures on the rising clock edge.

The opmode controls act combinationally at the stage that uses them. The pre-adder bits act at the pre-adder, between the B0 and B1 registers. The Z-select bits act at the post-adder, in front of the P register.

Top module: `mac_slice`

## Requirements
- R1: While all resets are high, every stage holds zero, so `p` reads zero.
- R2: With every register kept, a value on `a` reaches `p` after four rising edges. With every register removed, `p` follows the inputs in the same cycle.
- R3: When opmode bit 4 is 1 and opmode bit 1 is 0, the multiplier's B-side operand is D + B0, wrapped to 18 bits.
- R4: When opmode bit 4 is 1 and opmode bit 1 is 1, the B-side operand is D − B0, wrapped to 18 bits.
- R5: When opmode bit 4 is 0, the B-side operand is B0 itself, and the value on `d` has no effect on `p`.
- R6: Opmode bits 3:2 = 00 select Z = 0, so P takes the signed 36-bit product sign-extended to 48 bits.
- R7: Opmode bits 3:2 = 01 or 11 select Z = `c`, so P takes the extended product plus C.
- R8: Opmode bits 3:2 = 10 select Z = the registered P, so each enabled edge adds the product to P. With the P register removed, this Z is zero.
- R9: When a stage's enable is low, the stage holds its value. `ce_a` drives both A stages and `ce_b` drives both B stages.
- R10: When a stage's reset is high on a rising edge, the stage clears to zero, whatever its enable is.
- R11: The post-adder sum wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| opmode | input | 4 (bits 4:1) | Bit 4 pre-adder on, bit 1 subtract, bits 3:2 Z-select |
| a | input | AW | Multiplicand A |
| b | input | BW | Operand B |
| d | input | BW | Pre-adder operand D |
| c | input | PW | External post-adder operand |
| ce_a | input | 1 | Enable for both A stages |
| ce_b | input | 1 | Enable for both B stages |
| ce_d | input | 1 | Enable for the D stage |
| ce_m | input | 1 | Enable for the product stage |
| ce_p | input | 1 | Enable for the output stage |
| rst_a | input | 1 | Synchronous clear for both A stages |
| rst_b | input | 1 | Synchronous clear for both B stages |
| rst_d | input | 1 | Synchronous clear for the D stage |
| rst_m | input | 1 | Synchronous clear for the product stage |
| rst_p | input | 1 | Synchronous clear for the output stage |
| p | output | PW | Result / accumulator |

## Verification
Random full-range operands are run under each opmode in turn:
- pre-add against pre-subtract, which tells the sign of D − B from D + B;
- direct B with a random D, which shows that D has no effect;
- Z at zero, at C through both encodings, and at feedback, which separates multiply-only, multiply-plus-C and accumulate.

Further segments randomise the enables and resets while accumulating. These expose stages that ignore a hold or a clear, and any mix-up between the paired A and B controls.

Directed cases cover the following:
- a single impulse that measures latency;
- an enable-low hold and a reset that overrides an enable;
- C = all ones plus a unit product, which must wrap to zero.

A second instance with every register removed is checked in the same cycle, including feedback mode, where Z must be zero.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Z-select encodings (opmode bits 3:2)
  typedef enum logic [1:0] {
    ZS_ZERO  = 2'b00,
    ZS_C     = 2'b01,
    ZS_FB    = 2'b10,
    ZS_C_ALT = 2'b11
  } zsel_e;

  localparam int OPB_PRE_SUB = 1;
  localparam int OPB_PRE_EN  = 4;
endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int unsigned W   = 18,
  parameter int unsigned USE = 1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (USE != 0) begin : g_reg
      logic [W-1:0] r = '0;
      always_ff @(posedge clk) begin
        if (rst)     r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_preadd.sv
module mac_preadd #(
  parameter int unsigned W = 18
) (
  input  logic         en,
  input  logic         sub,
  input  logic [W-1:0] dv,
  input  logic [W-1:0] bv,
  output logic [W-1:0] y
);
  always_comb begin
    if (!en)      y = bv;
    else if (sub) y = dv - bv;
    else          y = dv + bv;
  end
endmodule

// File: rtl/mac_postadd.sv
module mac_postadd
  import mac_pkg::*;
#(
  parameter int unsigned PW = 48
) (
  input  zsel_e         zsel,
  input  logic [PW-1:0] prod_ext,
  input  logic [PW-1:0] cv,
  input  logic [PW-1:0] fb,
  output logic [PW-1:0] y
);
  logic [PW-1:0] z;
  always_comb begin
    unique case (zsel)
      ZS_ZERO:  z = '0;
      ZS_FB:    z = fb;
      ZS_C,
      ZS_C_ALT: z = cv;
      default:  z = '0;
    endcase
    y = prod_ext + z;
  end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int unsigned AW     = 18,
  parameter int unsigned BW     = 18,
  parameter int unsigned PW     = 48,
  parameter int unsigned USE_A0 = 1,
  parameter int unsigned USE_A1 = 1,
  parameter int unsigned USE_B0 = 1,
  parameter int unsigned USE_B1 = 1,
  parameter int unsigned USE_D  = 1,
  parameter int unsigned USE_M  = 1,
  parameter int unsigned USE_P  = 1
) (
  input  logic          clk,
  input  logic [4:1]    opmode,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [BW-1:0] d,
  input  logic [PW-1:0] c,
  input  logic          ce_a,
  input  logic          ce_b,
  input  logic          ce_d,
  input  logic          ce_m,
  input  logic          ce_p,
  input  logic          rst_a,
  input  logic          rst_b,
  input  logic          rst_d,
  input  logic          rst_m,
  input  logic          rst_p,
  output logic [PW-1:0] p
);
  localparam int unsigned MW = AW + BW;
  localparam int unsigned XW = PW - MW;

  logic [AW-1:0] a0_q, a1_q;
  logic [BW-1:0] b0_q, pre_y, b1_q, d_q;
  logic signed [MW-1:0] prod;
  logic [MW-1:0] m_q;
  logic [PW-1:0] m_ext, sum, p_q, fb;
  zsel_e zsel;

  // A path: two stages sharing enable and reset
  mac_pipe_reg #(.W(AW), .USE(USE_A0)) u_a0 (.clk(clk), .ce(ce_a), .rst(rst_a), .d(a),    .q(a0_q));
  mac_pipe_reg #(.W(AW), .USE(USE_A1)) u_a1 (.clk(clk), .ce(ce_a), .rst(rst_a), .d(a0_q), .q(a1_q));

  // B path: B0, pre-adder, B1; D feeds the pre-adder
  mac_pipe_reg #(.W(BW), .USE(USE_B0)) u_b0 (.clk(clk), .ce(ce_b), .rst(rst_b), .d(b), .q(b0_q));
  mac_pipe_reg #(.W(BW), .USE(USE_D))  u_d  (.clk(clk), .ce(ce_d), .rst(rst_d), .d(d), .q(d_q));

  mac_preadd #(.W(BW)) u_pre (
    .en (opmode[OPB_PRE_EN]),
    .sub(opmode[OPB_PRE_SUB]),
    .dv (d_q),
    .bv (b0_q),
    .y  (pre_y)
  );

  mac_pipe_reg #(.W(BW), .USE(USE_B1)) u_b1 (.clk(clk), .ce(ce_b), .rst(rst_b), .d(pre_y), .q(b1_q));

  // Signed multiply and product stage
  assign prod = $signed(a1_q) * $signed(b1_q);
  mac_pipe_reg #(.W(MW), .USE(USE_M)) u_m (.clk(clk), .ce(ce_m), .rst(rst_m), .d(prod), .q(m_q));
  assign m_ext = {{XW{m_q[MW-1]}}, m_q};

  // Post-adder with Z select; feedback only exists when P is registered
  assign zsel = zsel_e'(opmode[3:2]);
  generate
    if (USE_P != 0) begin : g_fb
      assign fb = p_q;
    end else begin : g_nofb
      assign fb = '0;
    end
  endgenerate

  mac_postadd #(.PW(PW)) u_post (
    .zsel    (zsel),
    .prod_ext(m_ext),
    .cv      (c),
    .fb      (fb),
    .y       (sum)
  );

  mac_pipe_reg #(.W(PW), .USE(USE_P)) u_p (.clk(clk), .ce(ce_p), .rst(rst_p), .d(sum), .q(p_q));
  assign p = p_q;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int unsigned AW     = 18,
  parameter int unsigned PW     = 48,
  parameter int unsigned USE_A1 = 1,
  parameter int unsigned USE_P  = 1
) (
  input logic          clk,
  input logic [1:0]    zs,
  input logic          ce_a,
  input logic          rst_a,
  input logic          ce_p,
  input logic          rst_p,
  input logic [AW-1:0] a1_q,
  input logic [PW-1:0] m_ext,
  input logic [PW-1:0] p_q
);
  generate
    if (USE_P != 0) begin : g_p
      logic rst_p_d = 1'b0;
      always_ff @(posedge clk) rst_p_d <= rst_p;

      always @(negedge clk) begin
        if (rst_p_d) begin
          assert_rst_clears_p_R10: assert (p_q == '0);
        end
      end

      assert_p_hold_R9: assert property (@(posedge clk) disable iff (rst_p)
        !ce_p |=> $stable(p_q));

      assert_zero_z_R6: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && zs == 2'b00) |=> (p_q == $past(m_ext)));

      assert_accumulate_R8: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && zs == 2'b10) |=> (p_q == $past(p_q) + $past(m_ext)));
    end
    if (USE_A1 != 0) begin : g_a
      assert_a_hold_R9: assert property (@(posedge clk) disable iff (rst_a)
        !ce_a |=> $stable(a1_q));
    end
  endgenerate
endmodule

bind mac_slice mac_slice_chk #(
  .AW(AW), .PW(PW), .USE_A1(USE_A1), .USE_P(USE_P)
) u_chk (
  .clk  (clk),
  .zs   (opmode[3:2]),
  .ce_a (ce_a),
  .rst_a(rst_a),
  .ce_p (ce_p),
  .rst_p(rst_p),
  .a1_q (a1_q),
  .m_ext(m_ext),
  .p_q  (p_q)
);

// File: tb/mac_slice_tb_top.sv
module mac_slice_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:1]  opmode = '0;
  logic [17:0] a = '0, b = '0, d = '0;
  logic [47:0] c = '0;
  logic ce_a = 1, ce_b = 1, ce_d = 1, ce_m = 1, ce_p = 1;
  logic rst_a = 1, rst_b = 1, rst_d = 1, rst_m = 1, rst_p = 1;
  logic [47:0] p_out, nb_p;

  mac_slice dut_i (
    .clk(clk), .opmode(opmode), .a(a), .b(b), .d(d), .c(c),
    .ce_a(ce_a), .ce_b(ce_b), .ce_d(ce_d), .ce_m(ce_m), .ce_p(ce_p),
    .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_m(rst_m), .rst_p(rst_p),
    .p(p_out)
  );

  mac_slice #(
    .USE_A0(0), .USE_A1(0), .USE_B0(0), .USE_B1(0), .USE_D(0), .USE_M(0), .USE_P(0)
  ) nb_i (
    .clk(clk), .opmode(opmode), .a(a), .b(b), .d(d), .c(c),
    .ce_a(ce_a), .ce_b(ce_b), .ce_d(ce_d), .ce_m(ce_m), .ce_p(ce_p),
    .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_m(rst_m), .rst_p(rst_p),
    .p(nb_p)
  );

  int pass_cnt = 0;
  int fail_cnt = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference functions taken from the requirements
  function automatic logic [17:0] pre_f(logic en, logic sub, logic [17:0] dv, logic [17:0] bv);
    if (!en) return bv;
    return sub ? dv - bv : dv + bv;
  endfunction

  function automatic logic [47:0] mul_ext(logic [17:0] x, logic [17:0] y);
    logic signed [35:0] pr;
    pr = $signed(x) * $signed(y);
    return {{12{pr[35]}}, pr};
  endfunction

  function automatic logic [47:0] z_f(logic [1:0] zs, logic [47:0] cv, logic [47:0] fbv);
    case (zs)
      2'b00: return '0;
      2'b10: return fbv;
      default: return cv;
    endcase
  endfunction

  // Cycle model of the fully registered slice
  logic [17:0] ma0 = '0, ma1 = '0, mb0 = '0, mb1 = '0, md = '0;
  logic [47:0] mm = '0, mp = '0;
  always @(posedge clk) begin
    if (rst_a) begin ma0 <= '0; ma1 <= '0; end
    else if (ce_a) begin ma0 <= a; ma1 <= ma0; end
    if (rst_b) begin mb0 <= '0; mb1 <= '0; end
    else if (ce_b) begin mb0 <= b; mb1 <= pre_f(opmode[4], opmode[1], md, mb0); end
    if (rst_d) md <= '0; else if (ce_d) md <= d;
    if (rst_m) mm <= '0; else if (ce_m) mm <= mul_ext(ma1, mb1);
    if (rst_p) mp <= '0; else if (ce_p) mp <= mm + z_f(opmode[3:2], c, mp);
  end

  function automatic logic [47:0] nb_exp();
    logic [1:0] zs;
    zs = opmode[3:2];
    return mul_ext(a, pre_f(opmode[4], opmode[1], d, b)) + ((zs == 2'b10) ? 48'd0 : z_f(zs, c, 48'd0));
  endfunction

  task automatic chk(logic [47:0] act, logic [47:0] exp, string tag);
    if (act === exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(p_out, mp, cur_req);
    chk(nb_p, nb_exp(), {cur_req, "/R2 bypass"});
  endtask

  task automatic all_ctl(logic ce, logic rs);
    ce_a = ce; ce_b = ce; ce_d = ce; ce_m = ce; ce_p = ce;
    rst_a = rs; rst_b = rs; rst_d = rs; rst_m = rs; rst_p = rs;
  endtask

  // mode: 0 = free run, 1 = random enables, 2 = random enables and resets
  task automatic run_seg(string tag, logic [4:1] op, int n, int mode);
    cur_req = tag;
    opmode = op;
    for (int i = 0; i < n; i++) begin
      a = 18'($urandom); b = 18'($urandom); d = 18'($urandom);
      c = {16'($urandom), 32'($urandom)};
      all_ctl(1'b1, 1'b0);
      if (mode >= 1) begin
        ce_a = ($urandom % 4) != 0; ce_b = ($urandom % 4) != 0;
        ce_d = ($urandom % 4) != 0; ce_m = ($urandom % 4) != 0;
        ce_p = ($urandom % 4) != 0;
      end
      if (mode >= 2) begin
        rst_a = ($urandom % 12) == 0; rst_b = ($urandom % 12) == 0;
        rst_d = ($urandom % 12) == 0; rst_m = ($urandom % 12) == 0;
        rst_p = ($urandom % 12) == 0;
      end
      tick();
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  initial begin
    logic [47:0] held;
    void'($urandom(32'h00C0FFEE));
    // R1: reset state, with busy inputs applied
    a = 18'h1234; b = 18'h0777; d = 18'h0055; c = 48'h1;
    all_ctl(1'b1, 1'b1);
    cur_req = "R1";
    repeat (3) tick();
    chk(p_out, 48'd0, "R1 reset value");

    // R2: impulse latency through four registers
    a = '0; b = '0; d = '0; c = '0; opmode = 4'b0000;
    tick();
    all_ctl(1'b1, 1'b0);
    cur_req = "R2";
    a = 18'd3; b = 18'd5;
    tick();
    a = '0; b = '0;
    tick(); tick();
    chk(p_out, 48'd0, "R2 not before 4 edges");
    tick();
    chk(p_out, 48'd15, "R2 value at 4 edges");

    // Opmode coverage with full-range random operands
    run_seg("R3", 4'b1000, 40, 0);
    run_seg("R4", 4'b1001, 40, 0);
    run_seg("R5", 4'b0001, 40, 0);
    run_seg("R6", 4'b0000, 40, 0);
    run_seg("R7", 4'b0010, 40, 0);
    run_seg("R7", 4'b0110, 40, 0);
    run_seg("R8", 4'b0100, 60, 0);
    run_seg("R8", 4'b1100, 60, 0);
    run_seg("R9", 4'b1100, 200, 1);
    run_seg("R10", 4'b0101, 300, 2);

    // R9: directed hold on P while accumulating
    cur_req = "R9";
    all_ctl(1'b1, 1'b0);
    opmode = 4'b0100; a = 18'd1; b = 18'd2;
    repeat (5) tick();
    ce_p = 1'b0;
    tick();
    held = p_out;
    repeat (3) tick();
    chk(p_out, held, "R9 P held with ce_p low");

    // R10: reset wins over a low enable
    cur_req = "R10";
    rst_p = 1'b1;
    tick();
    chk(p_out, 48'd0, "R10 reset overrides enable");
    rst_p = 1'b0; ce_p = 1'b1;

    // R11: wrap of the post-adder
    cur_req = "R11";
    all_ctl(1'b1, 1'b1);
    tick();
    all_ctl(1'b1, 1'b0);
    opmode = 4'b0010; a = 18'd1; b = 18'd1; d = '0; c = {48{1'b1}};
    repeat (4) tick();
    chk(p_out, 48'd0, "R11 product 1 plus all-ones wraps");

    done = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule